// File: doc/BRIEF.md
# RTS/CTS Hardware Handshake Controller

This block performs automatic hardware handshaking for a single asynchronous serial channel. On the receive side it watches how many bytes sit in the receive FIFO (0 to 64) and drives the active-low request-to-send output. It releases that line once the FIFO reaches a programmable stop threshold. It pulls the line low again only after the FIFO has drained to a separate, lower restart threshold. The gap between the two thresholds keeps the line from toggling on every byte.

On the transmit side it synchronises the active-low clear-to-send input and decides when the serializer may begin a new character. A character that has already begun always runs to the end of its stop bit, whatever the clear-to-send line does meanwhile. When automatic receive handshaking is off, the request-to-send output simply mirrors a manual control bit. Two sticky interrupt requests report changes on either handshake line. Both are cleared by a modem-status read strobe.

Both thresholds come from one 8-bit setting. Bits 3:0 hold the stop threshold and bits 7:4 hold the restart threshold, each in units of 4 bytes. The FIFO storage, the serializer itself and any in-band flow control lie outside this block.

Top module: `rts_cts_flowctl`

## Requirements
- R1: After reset, rts_n is 1, tx_start and tx_active are 0, and both interrupt requests are 0.
- R2: With cfg_auto_rts_en at 0, rts_n equals the inverse of cfg_rts_bit one clock after it is sampled.
- R3: With automatic receive handshaking active, rts_n goes to 1 one clock after rx_fill is at or above 4 × cfg_levels[3:0]. Active means cfg_auto_rts_en = 1, cfg_rts_bit = 1 and 4 × cfg_levels[7:4] < 4 × cfg_levels[3:0].
- R4: While active, rts_n returns to 0 one clock after rx_fill is at or below 4 × cfg_levels[7:4]. For fills strictly between the two thresholds it keeps its previous value.
- R5: If the restart threshold is not below the stop threshold, the automatic function acts as disabled, and rts_n = ~cfg_rts_bit.
- R6: With cfg_auto_rts_en = 1 but cfg_rts_bit = 0, rts_n stays 1 at every fill level.
- R7: With cfg_auto_cts_en = 1, tx_start is asserted only while the synchronised cts_n is 0. A change on cts_n reaches tx_start after two clock edges.
- R8: Once tx_start has been asserted, tx_active is 1 from the next clock until the clock that samples tx_char_done. During that time tx_start stays 0 and changes on cts_n have no effect on tx_active.
- R9: With cfg_auto_cts_en = 0, cts_n is ignored and tx_start = tx_char_req & ~tx_active.
- R10: When irq_en_rts = 1, a change on rts_n sets irq_rts on the following clock. With irq_en_rts = 0, irq_rts is never set.
- R11: When irq_en_cts = 1, a change of the synchronised cts_n sets irq_cts on the following clock, three clocks after the pin changes.
- R12: msr_read clears both interrupt requests on the next clock. If a new change is detected in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_auto_rts_en | input | 1 | Enable automatic receive handshaking |
| cfg_auto_cts_en | input | 1 | Enable automatic transmit gating |
| cfg_rts_bit | input | 1 | Manual request-to-send bit (1 = drive line low) |
| cfg_levels | input | 8 | Bits 3:0 stop threshold, bits 7:4 restart threshold, in 4-byte units |
| rx_fill | input | 7 | Current receive FIFO fill, 0..64 |
| rts_n | output | 1 | Active-low request-to-send |
| cts_n | input | 1 | Active-low clear-to-send, asynchronous |
| tx_char_req | input | 1 | Serializer holds a character ready to start |
| tx_char_done | input | 1 | Serializer finished the stop bit of the current character |
| tx_start | output | 1 | Grant to begin the next character |
| tx_active | output | 1 | A granted character is still in flight |
| irq_en_rts | input | 1 | Arm the request-to-send change interrupt |
| irq_en_cts | input | 1 | Arm the clear-to-send change interrupt |
| msr_read | input | 1 | Modem-status read strobe, clears interrupts |
| irq_rts | output | 1 | Request-to-send change interrupt |
| irq_cts | output | 1 | Clear-to-send change interrupt |

## Verification
On every cycle, the assertions check the threshold responses of rts_n, the manual-mode mirroring, and the absence of a second grant while a character is in flight. They also check that tx_active holds until the done strobe, that a disarmed interrupt stays quiet, and that a modem-status read clears an interrupt when no new change has arrived. Only the bench scenarios can show the hold band between the two thresholds along a fill trajectory, the two-edge latency of the clear-to-send synchroniser, and the three-clock arrival of its interrupt. The same applies to the set-wins collision with a read, and to a clear-to-send rise in mid-character leaving the character to finish.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
    localparam int FC_FILL_W   = 7;
    localparam int FC_NIB_W    = 4;
    localparam int FC_SCALE_SH = 2;
    localparam int FC_SYNC_N   = 2;

    typedef struct packed {
        logic halted;
        logic rts_n;
    } rts_state_t;

    typedef struct packed {
        logic busy;
    } gate_state_t;

    typedef struct packed {
        logic rts_prev;
        logic cts_prev;
        logic irq_rts;
        logic irq_cts;
    } irq_state_t;
endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/fc_rts_hyst.sv
module fc_rts_hyst
    import flowctl_pkg::*;
#(
    parameter int FILL_W   = FC_FILL_W,
    parameter int NIB_W    = FC_NIB_W,
    parameter int SCALE_SH = FC_SCALE_SH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 auto_en,
    input  logic                 man_bit,
    input  logic [2*NIB_W-1:0]   levels,
    input  logic [FILL_W-1:0]    fill,
    output logic                 rts_n
);
    localparam int LVL_W = NIB_W + SCALE_SH;

    rts_state_t st_d, st_q;
    logic [LVL_W-1:0]  stop_raw, go_raw;
    logic [FILL_W-1:0] stop_lvl, go_lvl;
    logic              active;

    always_comb begin
        stop_raw = {levels[NIB_W-1:0], {SCALE_SH{1'b0}}};
        go_raw   = {levels[2*NIB_W-1:NIB_W], {SCALE_SH{1'b0}}};
        stop_lvl = FILL_W'(stop_raw);
        go_lvl   = FILL_W'(go_raw);
        active   = auto_en && man_bit && (go_lvl < stop_lvl);

        st_d = st_q;
        if (!active) begin
            st_d.halted = 1'b0;
            st_d.rts_n  = ~man_bit;
        end else begin
            if (fill >= stop_lvl)     st_d.halted = 1'b1;
            else if (fill <= go_lvl)  st_d.halted = 1'b0;
            st_d.rts_n = st_d.halted;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{halted: 1'b0, rts_n: 1'b1};
        else        st_q <= st_d;
    end

    assign rts_n = st_q.rts_n;
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate
    import flowctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic cts_sync_n,
    input  logic req,
    input  logic done,
    output logic start,
    output logic active
);
    gate_state_t st_d, st_q;
    logic        allow;

    always_comb begin
        allow = !auto_en || !cts_sync_n;
        start = req && !st_q.busy && allow;
        st_d  = st_q;
        if (st_q.busy) begin
            if (done) st_d.busy = 1'b0;
        end else if (start) begin
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{busy: 1'b0};
        else        st_q <= st_d;
    end

    assign active = st_q.busy;
endmodule

// File: rtl/fc_irq.sv
module fc_irq
    import flowctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_rts,
    input  logic en_cts,
    input  logic rts_line,
    input  logic cts_line,
    input  logic clr,
    output logic irq_rts,
    output logic irq_cts
);
    irq_state_t st_d, st_q;
    logic       rts_chg, cts_chg;

    always_comb begin
        rts_chg = rts_line != st_q.rts_prev;
        cts_chg = cts_line != st_q.cts_prev;
        st_d          = st_q;
        st_d.rts_prev = rts_line;
        st_d.cts_prev = cts_line;
        if (clr) begin
            st_d.irq_rts = 1'b0;
            st_d.irq_cts = 1'b0;
        end
        if (en_rts && rts_chg) st_d.irq_rts = 1'b1;
        if (en_cts && cts_chg) st_d.irq_cts = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{rts_prev: 1'b1, cts_prev: 1'b1, irq_rts: 1'b0, irq_cts: 1'b0};
        else        st_q <= st_d;
    end

    assign irq_rts = st_q.irq_rts;
    assign irq_cts = st_q.irq_cts;
endmodule

// File: rtl/rts_cts_flowctl.sv
module rts_cts_flowctl
    import flowctl_pkg::*;
#(
    parameter int FILL_W   = FC_FILL_W,
    parameter int NIB_W    = FC_NIB_W,
    parameter int SCALE_SH = FC_SCALE_SH,
    parameter int SYNC_N   = FC_SYNC_N
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_auto_rts_en,
    input  logic               cfg_auto_cts_en,
    input  logic               cfg_rts_bit,
    input  logic [2*NIB_W-1:0] cfg_levels,
    input  logic [FILL_W-1:0]  rx_fill,
    output logic               rts_n,
    input  logic               cts_n,
    input  logic               tx_char_req,
    input  logic               tx_char_done,
    output logic               tx_start,
    output logic               tx_active,
    input  logic               irq_en_rts,
    input  logic               irq_en_cts,
    input  logic               msr_read,
    output logic               irq_rts,
    output logic               irq_cts
);
    logic cts_s;

    fc_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(cts_n), .dout(cts_s)
    );

    fc_rts_hyst #(.FILL_W(FILL_W), .NIB_W(NIB_W), .SCALE_SH(SCALE_SH)) u_rts (
        .clk(clk), .rst_n(rst_n), .auto_en(cfg_auto_rts_en), .man_bit(cfg_rts_bit),
        .levels(cfg_levels), .fill(rx_fill), .rts_n(rts_n)
    );

    fc_tx_gate u_gate (
        .clk(clk), .rst_n(rst_n), .auto_en(cfg_auto_cts_en), .cts_sync_n(cts_s),
        .req(tx_char_req), .done(tx_char_done), .start(tx_start), .active(tx_active)
    );

    fc_irq u_irq (
        .clk(clk), .rst_n(rst_n), .en_rts(irq_en_rts), .en_cts(irq_en_cts),
        .rts_line(rts_n), .cts_line(cts_s), .clr(msr_read),
        .irq_rts(irq_rts), .irq_cts(irq_cts)
    );
endmodule

// File: rtl/rts_cts_flowctl_chk.sv
module rts_cts_flowctl_chk #(
    parameter int FILL_W   = 7,
    parameter int NIB_W    = 4,
    parameter int SCALE_SH = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_auto_rts_en,
    input logic               cfg_auto_cts_en,
    input logic               cfg_rts_bit,
    input logic [2*NIB_W-1:0] cfg_levels,
    input logic [FILL_W-1:0]  rx_fill,
    input logic               rts_n,
    input logic               cts_n,
    input logic               tx_char_req,
    input logic               tx_char_done,
    input logic               tx_start,
    input logic               tx_active,
    input logic               irq_en_rts,
    input logic               irq_en_cts,
    input logic               msr_read,
    input logic               irq_rts,
    input logic               irq_cts
);
    int unsigned stop_b, go_b;
    logic        act;
    always_comb begin
        stop_b = int'(cfg_levels[NIB_W-1:0]) << SCALE_SH;
        go_b   = int'(cfg_levels[2*NIB_W-1:NIB_W]) << SCALE_SH;
        act    = cfg_auto_rts_en && cfg_rts_bit && (go_b < stop_b);
    end

    // R2
    manual_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_auto_rts_en |=> (rts_n == !$past(cfg_rts_bit)));
    // R3
    halt_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && int'(rx_fill) >= stop_b) |=> rts_n);
    // R4
    resume_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && int'(rx_fill) <= go_b) |=> !rts_n);
    // R8
    no_regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> !tx_start);
    // R8
    hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !tx_char_done) |=> tx_active);
    // R10
    rts_irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en_rts && !irq_rts) |=> !irq_rts);
    // R12
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_read && $stable(rts_n)) |=> !irq_rts);
endmodule

bind rts_cts_flowctl rts_cts_flowctl_chk #(.FILL_W(FILL_W), .NIB_W(NIB_W), .SCALE_SH(SCALE_SH)) u_chk (.*);

// File: tb/rts_cts_flowctl_tb.sv
module rts_cts_flowctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_auto_rts_en = 0, cfg_auto_cts_en = 0, cfg_rts_bit = 0;
    logic [7:0] cfg_levels = 8'h00;
    logic [6:0] rx_fill = '0;
    logic       rts_n, cts_n = 1'b1;
    logic       tx_char_req = 0, tx_char_done = 0;
    logic       tx_start, tx_active;
    logic       irq_en_rts = 0, irq_en_cts = 0, msr_read = 0;
    logic       irq_rts, irq_cts;

    int n_chk = 0, n_err = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    rts_cts_flowctl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_auto_rts_en(cfg_auto_rts_en),
        .cfg_auto_cts_en(cfg_auto_cts_en), .cfg_rts_bit(cfg_rts_bit),
        .cfg_levels(cfg_levels), .rx_fill(rx_fill), .rts_n(rts_n), .cts_n(cts_n),
        .tx_char_req(tx_char_req), .tx_char_done(tx_char_done), .tx_start(tx_start),
        .tx_active(tx_active), .irq_en_rts(irq_en_rts), .irq_en_cts(irq_en_cts),
        .msr_read(msr_read), .irq_rts(irq_rts), .irq_cts(irq_cts)
    );

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic m_active(logic a, logic b, logic [7:0] lv);
        return a && b && (int'(lv[7:4]) * 4 < int'(lv[3:0]) * 4);
    endfunction

    function automatic logic m_halt(logic act, logic [6:0] f, logic [7:0] lv, logic prev);
        if (!act) return 1'b0;
        if (int'(f) >= int'(lv[3:0]) * 4) return 1'b1;
        if (int'(f) <= int'(lv[7:4]) * 4) return 1'b0;
        return prev;
    endfunction

    initial begin
        #1000000;
        if (!done_flag) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic halted, exp_r, busy, act;
        int   cts_age;
        void'($urandom(32'h5eed_0042));
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        step(1);
        chk("R1 rts_n", rts_n, 1'b1);
        chk("R1 tx_start", tx_start, 1'b0);
        chk("R1 tx_active", tx_active, 1'b0);
        chk("R1 irq_rts", irq_rts, 1'b0);
        chk("R1 irq_cts", irq_cts, 1'b0);

        // R2 manual mode
        cfg_rts_bit = 1; step(1); chk("R2 low", rts_n, 1'b0);
        cfg_rts_bit = 0; step(1); chk("R2 high", rts_n, 1'b1);

        // R3/R4: stop 32, restart 8
        cfg_levels = 8'h28; cfg_auto_rts_en = 1; cfg_rts_bit = 1; rx_fill = 0;
        step(1); chk("R4 start low", rts_n, 1'b0);
        rx_fill = 31; step(1); chk("R3 below stop", rts_n, 1'b0);
        rx_fill = 32; step(1); chk("R3 at stop", rts_n, 1'b1);
        rx_fill = 20; step(1); chk("R4 hold high", rts_n, 1'b1);
        rx_fill = 9;  step(1); chk("R4 above restart", rts_n, 1'b1);
        rx_fill = 8;  step(1); chk("R4 at restart", rts_n, 1'b0);
        rx_fill = 20; step(1); chk("R4 hold low", rts_n, 1'b0);
        rx_fill = 64; step(1); chk("R3 full", rts_n, 1'b1);

        // R6
        cfg_rts_bit = 0; rx_fill = 0; step(1); chk("R6 empty", rts_n, 1'b1);
        rx_fill = 64; step(1); chk("R6 full", rts_n, 1'b1);

        // R5 invalid levels
        cfg_rts_bit = 1; cfg_levels = 8'h44; rx_fill = 60; step(1);
        chk("R5 equal", rts_n, 1'b0);
        cfg_levels = 8'h84; step(1); chk("R5 inverted", rts_n, 1'b0);

        // R10 interrupt on rts change
        cfg_auto_rts_en = 0; msr_read = 1; step(1); msr_read = 0;
        irq_en_rts = 1; cfg_rts_bit = 0; step(1);
        chk("R10 not yet", irq_rts, 1'b0);
        step(1); chk("R10 set", irq_rts, 1'b1);
        step(2); chk("R10 sticky", irq_rts, 1'b1);
        msr_read = 1; step(1); msr_read = 0; chk("R12 cleared", irq_rts, 1'b0);
        // R12 collision: set wins
        cfg_rts_bit = 1; step(1); msr_read = 1; step(1); msr_read = 0;
        chk("R12 set wins", irq_rts, 1'b1);
        msr_read = 1; step(1); msr_read = 0;
        irq_en_rts = 0; cfg_rts_bit = 0; step(3);
        chk("R10 disarmed", irq_rts, 1'b0);

        // R7/R8/R11 transmit gating
        irq_en_cts = 1; cfg_auto_cts_en = 1; cts_n = 1; tx_char_req = 1;
        step(3); chk("R7 blocked", tx_start, 1'b0);
        cts_n = 0; step(1); chk("R7 sync latency", tx_start, 1'b0);
        step(1); chk("R7 granted", tx_start, 1'b1);
        chk("R11 not yet", irq_cts, 1'b0);
        step(1); chk("R8 active", tx_active, 1'b1); chk("R8 no regrant", tx_start, 1'b0);
        chk("R11 set", irq_cts, 1'b1);
        cts_n = 1; step(3); chk("R8 not cut", tx_active, 1'b1);
        tx_char_done = 1; step(1); tx_char_done = 0;
        chk("R8 finished", tx_active, 1'b0); chk("R7 blocked again", tx_start, 1'b0);
        msr_read = 1; step(1); msr_read = 0; chk("R12 cts cleared", irq_cts, 1'b0);
        cfg_auto_cts_en = 0; #1; chk("R9 ignored", tx_start, 1'b1);
        step(1); chk("R9 active", tx_active, 1'b1);
        tx_char_done = 1; step(1); tx_char_done = 0; tx_char_req = 0;

        // Random phase
        cfg_levels = 8'h38; cfg_auto_rts_en = 1; cfg_rts_bit = 1; irq_en_cts = 0;
        halted = 0; busy = tx_active; cts_age = 10; rx_fill = 0;
        step(1); halted = 0;
        for (int it = 0; it < 4000; it++) begin
            int r = int'($urandom_range(0, 99));
            int f = int'(rx_fill);
            f = f + int'($urandom_range(0, 6)) - 3;
            if (f < 0) f = 0;
            if (f > 64) f = 64;
            rx_fill = 7'(f);
            if (r < 2) cfg_auto_rts_en = ~cfg_auto_rts_en;
            if (r == 3) cfg_rts_bit = ~cfg_rts_bit;
            if (r >= 90) begin cts_n = ~cts_n; cts_age = 0; end
            if (r == 50) cfg_auto_cts_en = ~cfg_auto_cts_en;
            tx_char_req = 1'($urandom_range(0, 1));
            tx_char_done = busy && ($urandom_range(0, 3) == 0);
            act = m_active(cfg_auto_rts_en, cfg_rts_bit, cfg_levels);
            #1;
            if (cts_age >= 2 || !cfg_auto_cts_en)
                chk("R7/R9 random grant", tx_start,
                    tx_char_req && !busy && (!cfg_auto_cts_en || !cts_n));
            chk("R8 random active", tx_active, busy);
            halted = m_halt(act, rx_fill, cfg_levels, halted);
            exp_r  = act ? halted : ~cfg_rts_bit;
            busy   = busy ? !tx_char_done : tx_start;
            step(1);
            cts_age++;
            chk("R3/R4 random rts", rts_n, exp_r);
        end

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule